// File: doc/BRIEF.md
# Expansion Module Discovery Engine

This block is a small two-wire bus master that finds out which expansion modules are plugged into a modular controller. Every module carries a 3-bit strap address, so at most eight can be fitted. Each module may hold up to two kinds of addressable device: an identification device and an I/O-expander device. Their fixed upper four address bits differ, so both kinds can share one strap address. The engine sends an address-only probe to all eight strap addresses of each kind. It records which probes were acknowledged as a presence bitmap per kind, together with a module count per kind. The counts are then used to size the input and output shift-bus scans.

A sweep starts on its own after reset, and again whenever a start command arrives while the engine is idle. The serial clock goes out on the shared bus clock line. SDA is open-drain: the engine only pulls it low or releases it, and it reads the wire back to take the acknowledge. While a sweep runs, the engine holds a busy output high so that the shift-bus controllers keep off the shared clock line. A level interrupt from the I/O-expander modules needs no bus traffic: it is passed through a two-stage synchronizer.

Top module: `mod_probe_sweep`

## Requirements
- R1: While reset is asserted, and after it until the first sweep begins, the clock output is high, SDA is released (sda_pull_o = 0), busy and done are low, and both bitmaps and both counts are zero.
- R2: A sweep begins by itself in the first cycle after reset is released. Later sweeps begin when start_i is high in a cycle where the engine is idle. A new sweep clears the bitmaps, the counts and done.
- R3: Each probe is framed as a START, then eight bits sent MSB first, then a ninth acknowledge bit with SDA released, then a STOP. The eight bits are {type code[3:0], strap address[2:0], 1'b0}. The type code is ID_HI for kind 0 and XP_HI for kind 1. A sweep makes 16 probes: kind 0 at addresses 0 to 7 in order, then kind 1 at addresses 0 to 7.
- R4: SDA changes while the clock output is high only to form a START (falling) or a STOP (rising). Every other SDA change happens while the clock is low.
- R5: When SDA reads low on the acknowledge bit, bit a of that kind's bitmap is set, where a is the probed address. When SDA reads high, the bit stays 0.
- R6: When done is high, each count equals the number of ones in its bitmap.
- R7: busy is high for the whole sweep. done rises together with busy falling, exactly 704*(div_i+1) clock cycles after the sweep began, and stays high until the next sweep.
- R8: div_i is sampled only when a sweep begins. A start request, or a change on div_i, during a sweep has no effect on that sweep's timing or results.
- R9: irq_o follows irq_i through two register stages, so it shows a change on irq_i two clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a new sweep when idle |
| div_i | input | DIV_W | Clock divider: each quarter bit lasts div_i+1 cycles |
| sda_i | input | 1 | Read-back of the SDA wire |
| irq_i | input | 1 | Data-ready interrupt from expander modules |
| scl_o | output | 1 | Serial clock onto the shared bus clock line |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | Sweep in progress; shift-bus controllers keep off the clock line |
| done_o | output | 1 | Last sweep finished |
| id_map_o | output | 8 | Acknowledged addresses of kind 0 |
| xp_map_o | output | 8 | Acknowledged addresses of kind 1 |
| id_cnt_o | output | 4 | Number of kind-0 modules found |
| xp_cnt_o | output | 4 | Number of kind-1 modules found |
| irq_o | output | 1 | Synchronized interrupt |

## Verification
Sweeps are run against slave populations that are empty, full, alternating, single-ended at address 0 or 7, and different for the two kinds. These show whether a bitmap bit lands on the right address and on the right kind, and whether the counts follow the bitmaps. Divider values from 0 to 3 separate correct bit timing from a tick that is one cycle off. A bus monitor decodes every address byte, START, STOP and SDA edge that occurs while the clock is high. A sweep with a mid-run start pulse and a change of divider shows whether the engine lets itself be disturbed while busy.

// File: rtl/mod_probe_sweep.sv
module mod_probe_sweep #(
  parameter int          DIV_W = 8,
  parameter logic [3:0]  ID_HI = 4'b1010,
  parameter logic [3:0]  XP_HI = 4'b0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             sda_i,
  input  logic             irq_i,
  output logic             scl_o,
  output logic             sda_pull_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [7:0]       id_map_o,
  output logic [7:0]       xp_map_o,
  output logic [3:0]       id_cnt_o,
  output logic [3:0]       xp_cnt_o,
  output logic             irq_o
);

  typedef enum logic [1:0] {S_IDLE, S_START, S_BIT, S_STOP} st_t;

  st_t              st;
  logic [1:0]       ph;
  logic [3:0]       bitn;
  logic [3:0]       probe;
  logic [DIV_W-1:0] cnt, div_q;
  logic             auto_q;
  logic [1:0]       irq_s;
  logic [7:0]       abyte;
  logic             tick, ack_slot;

  assign tick     = (cnt == div_q);
  assign abyte    = {(probe[3] ? XP_HI : ID_HI), probe[2:0], 1'b0};
  assign ack_slot = (st == S_BIT) && (bitn == 4'd8);
  assign busy_o   = (st != S_IDLE);
  assign irq_o    = irq_s[1];

  always_comb begin
    scl_o      = 1'b1;
    sda_pull_o = 1'b0;
    case (st)
      S_START: begin
        scl_o      = (ph != 2'd3);
        sda_pull_o = ph[1];
      end
      S_BIT: begin
        scl_o      = (ph == 2'd1) || (ph == 2'd2);
        sda_pull_o = !ack_slot && !abyte[3'd7 - bitn[2:0]];
      end
      S_STOP: begin
        scl_o      = (ph != 2'd0);
        sda_pull_o = !ph[1];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ph       <= '0;
      bitn     <= '0;
      probe    <= '0;
      cnt      <= '0;
      div_q    <= '0;
      auto_q   <= 1'b1;
      done_o   <= 1'b0;
      id_map_o <= '0;
      xp_map_o <= '0;
      id_cnt_o <= '0;
      xp_cnt_o <= '0;
      irq_s    <= '0;
    end else begin
      irq_s <= {irq_s[0], irq_i};
      if (st == S_IDLE) begin
        if (start_i || auto_q) begin
          auto_q   <= 1'b0;
          st       <= S_START;
          ph       <= '0;
          cnt      <= '0;
          div_q    <= div_i;
          probe    <= '0;
          done_o   <= 1'b0;
          id_map_o <= '0;
          xp_map_o <= '0;
          id_cnt_o <= '0;
          xp_cnt_o <= '0;
        end
      end else if (tick) begin
        cnt <= '0;
        ph  <= ph + 2'd1;
        if (ack_slot && ph == 2'd2 && !sda_i) begin
          if (probe[3]) begin
            xp_map_o[probe[2:0]] <= 1'b1;
            xp_cnt_o             <= xp_cnt_o + 4'd1;
          end else begin
            id_map_o[probe[2:0]] <= 1'b1;
            id_cnt_o             <= id_cnt_o + 4'd1;
          end
        end
        if (ph == 2'd3) begin
          case (st)
            S_START: begin
              st   <= S_BIT;
              bitn <= '0;
            end
            S_BIT: begin
              if (bitn == 4'd8) st <= S_STOP;
              else              bitn <= bitn + 4'd1;
            end
            S_STOP: begin
              if (probe == 4'd15) begin
                st     <= S_IDLE;
                done_o <= 1'b1;
              end else begin
                probe <= probe + 4'd1;
                st    <= S_START;
              end
            end
            default: st <= S_IDLE;
          endcase
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (scl_o && !sda_pull_o)); // R1
  AST_SDA_FALL_HIGH_IS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o && $past(scl_o) && $rose(sda_pull_o)) |-> (st == S_START)); // R4
  AST_SDA_RISE_HIGH_IS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o && $past(scl_o) && $fell(sda_pull_o)) |-> (st == S_STOP || st == S_IDLE)); // R4
  AST_ACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    ack_slot |-> !sda_pull_o); // R3
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R7
  AST_COUNT_MATCHES_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($countones(id_map_o) == id_cnt_o && $countones(xp_map_o) == xp_cnt_o)); // R6
  AST_DIV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(div_q)); // R8

endmodule

// File: tb/test_mod_probe_sweep.sv
module test_mod_probe_sweep;
  localparam int         CLK_PERIOD = 10;
  localparam logic [3:0] ID_HI = 4'b1010;
  localparam logic [3:0] XP_HI = 4'b0100;
  localparam int         NV = 7;
  localparam logic [17:0] VEC [NV] = '{
    {8'h00, 8'h00, 2'd0},
    {8'hFF, 8'hFF, 2'd1},
    {8'hA5, 8'h3C, 2'd0},
    {8'h01, 8'h80, 2'd2},
    {8'h80, 8'h00, 2'd3},
    {8'h00, 8'h5A, 2'd1},
    {8'h6E, 8'h6E, 2'd0}
  };

  logic clk = 0, rst_n = 0, start = 0, irq_in = 0;
  logic [7:0] div = 0;
  logic [7:0] pres_id = 0, pres_xp = 0;
  logic scl, sda_pull, busy, done, irq_out;
  logic [7:0] id_map, xp_map;
  logic [3:0] id_cnt, xp_cnt;
  logic acking = 0;
  wire  sda_line = !sda_pull && !acking;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mod_probe_sweep #(.DIV_W(8), .ID_HI(ID_HI), .XP_HI(XP_HI)) i_mod_probe_sweep (
    .clk(clk), .rst_n(rst_n), .start_i(start), .div_i(div), .sda_i(sda_line),
    .irq_i(irq_in), .scl_o(scl), .sda_pull_o(sda_pull), .busy_o(busy), .done_o(done),
    .id_map_o(id_map), .xp_map_o(xp_map), .id_cnt_o(id_cnt), .xp_cnt_o(xp_cnt),
    .irq_o(irq_out));

  // bus monitor and slave model
  logic p_scl = 1, p_sda = 1;
  logic [7:0] shr;
  int bitc = 10, n_start = 0, n_stop = 0, n_byte = 0, n_bad_byte = 0, n_hi_edges = 0;
  always @(negedge clk) begin
    if (p_scl && scl && (p_sda != sda_line)) n_hi_edges++;
    if (p_scl && scl && p_sda && !sda_line) begin
      n_start++; bitc = 0; acking = 0;
    end else if (p_scl && scl && !p_sda && sda_line) begin
      n_stop++;
    end
    if (!p_scl && scl && bitc < 8) begin
      shr = {shr[6:0], sda_line}; bitc++;
    end
    if (p_scl && !scl) begin
      if (bitc == 8) begin
        logic [7:0] exp_b;
        exp_b = {(n_byte >= 8 ? XP_HI : ID_HI), 3'(n_byte % 8), 1'b0};
        if (shr != exp_b) n_bad_byte++;
        n_byte++;
        acking = !shr[0] && ((shr[7:4] == ID_HI && pres_id[shr[3:1]]) ||
                             (shr[7:4] == XP_HI && pres_xp[shr[3:1]]));
        bitc = 9;
      end else if (bitc == 9) begin
        acking = 0; bitc = 10;
      end
    end
    p_scl = scl; p_sda = sda_line;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    n_start = 0; n_stop = 0; n_byte = 0; n_bad_byte = 0; n_hi_edges = 0;
  endtask

  function automatic int pop8(input logic [7:0] v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += v[i];
    return c;
  endfunction

  task automatic finish_sweep(input logic [7:0] eid, input logic [7:0] exp_xp, input int d,
                              input int n_to_done);
    check("R7 sweep length", n_to_done, 704 * (d + 1) + 1);
    check("R5 id map", id_map, eid);
    check("R5 xp map", xp_map, exp_xp);
    check("R6 id count", id_cnt, pop8(eid));
    check("R6 xp count", xp_cnt, pop8(exp_xp));
    check("R3 probes/starts/stops", {n_start[7:0], n_stop[7:0], n_byte[7:0]}, {8'd16, 8'd16, 8'd16});
    check("R3 address byte order", n_bad_byte, 0);
    check("R4 sda edges while scl high", n_hi_edges, 32);
    check("R7 busy low at done", busy, 0);
  endtask

  task automatic run_sweep(input logic [7:0] eid, input logic [7:0] exp_xp, input int d,
                           input bit disturb);
    int n = 0;
    bit seen_busy = 1;
    pres_id = eid; pres_xp = exp_xp; div = 8'(d);
    clear_mon();
    start = 1;
    @(negedge clk); start = 0; n = 1;
    while (!done && n < 20000) begin
      if (!busy) seen_busy = 0;
      if (disturb && n == 600) begin start = 1; div = 8'd7; end
      if (disturb && n == 601) start = 0;
      @(negedge clk); n++;
    end
    check("R7 busy through sweep", seen_busy, 1);
    finish_sweep(eid, exp_xp, d, n);
  endtask

  initial begin
    pres_id = 8'h42; pres_xp = 8'h81;
    repeat (3) @(negedge clk);
    check("R1 reset scl", scl, 1);
    check("R1 reset sda", sda_pull, 0);
    check("R1 reset busy/done", {busy, done}, 2'b00);
    check("R1 reset maps", {id_map, xp_map, id_cnt, xp_cnt}, 0);
    // R2: automatic sweep after reset
    rst_n = 1;
    begin
      int n = 0;
      @(negedge clk); n = 1;
      check("R2 auto start busy", busy, 1);
      while (!done && n < 20000) begin @(negedge clk); n++; end
      finish_sweep(8'h42, 8'h81, 0, n);
    end
    repeat (5) @(negedge clk);
    check("R7 done held until next start", done, 1);
    // vector table
    for (int v = 0; v < NV; v++) begin
      run_sweep(VEC[v][17:10], VEC[v][9:2], int'(VEC[v][1:0]), 0);
      repeat (3) @(negedge clk);
    end
    // R8: start and divider change while busy
    run_sweep(8'h18, 8'h24, 1, 1);
    // R2: start clears done
    div = 0; start = 1; @(negedge clk); start = 0;
    check("R2 start clears done", {busy, done}, 2'b10);
    while (!done) @(negedge clk);
    // R9: interrupt synchronizer
    irq_in = 1;
    @(negedge clk); check("R9 irq after one edge", irq_out, 0);
    @(negedge clk); check("R9 irq after two edges", irq_out, 1);
    irq_in = 0;
    @(negedge clk); @(negedge clk); check("R9 irq falls", irq_out, 0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule